// File: doc/BRIEF.md
# I2C Controller Interrupt Register File

This block gathers the event pulses of an I2C master controller into a sticky status register and turns them into one level-sensitive interrupt line. Each event source raises a one-cycle pulse. The pulse sets a status bit, and the bit stays set until software writes a one to that bit position at the status offset. A value just read from the status register can therefore be written straight back to acknowledge every event it contained.

The mask has no direct write port. Two write-only offsets change it instead: writing ones at the unmask offset enables sources, and writing ones at the mask offset disables them. The current mask reads back at its own offset. The interrupt output goes high when any status bit is set while its mask bit is enabled. It comes from a flop, so it cannot glitch. The register bus is a plain synchronous one: address, write strobe and write data in, and combinational read data out.

Top module: `irq_regs`

## Requirements
- R1: While reset is asserted and right after it, every status bit and every mask bit is 0, the interrupt output is 0, and reads at every offset return 0.
- R2: A one-cycle pulse on event input i sets status bit i. The bit is visible at offset 0x10 from the next cycle and stays set until it is cleared. The bit positions are fixed: 0 complete, 1 data, 2 NACK, 3 timeout, 4 slave ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: A write at offset 0x10 clears each status bit whose write-data bit is 1. Status bits written with 0 do not change.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write at offset 0x24 sets each mask bit whose write-data bit is 1. Mask bits written with 0 do not change.
- R6: A write at offset 0x28 clears each mask bit whose write-data bit is 1. Mask bits written with 0 do not change.
- R7: Offset 0x20 reads the mask in bits 9:0. Offsets 0x24 and 0x28 are write-only and read as 0.
- R8: Bit 8 and all bits above 9 read as 0 at every offset. Writes to those bits and events on input 8 have no effect.
- R9: The interrupt output in each cycle equals the OR, over all bits, of status AND mask as they stood in the previous cycle.
- R10: Writes to any offset other than 0x10, 0x24 and 0x28 change neither status nor mask, and unlisted offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtPulse | input | 10 | One-cycle event pulses, one per status bit |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Registered level interrupt |

## Verification
The assertions assume that every input is a known value, that it is driven away from the clock edge, and that a write lasts exactly the one cycle in which busWe is high. They also assume that event pulses may arrive at any time, including in the cycle of a clearing write or a mask update. The stimulus changes inputs only just after the falling edge. It mixes directed collisions with a stretch of random events, random offsets and random write data, and it deliberately includes the reserved bit and offsets outside the map, so every path stays inside those assumptions.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  localparam int ADDR_W_DEF = 8;
  localparam int DATA_W_DEF = 32;
  localparam int SRC_W_DEF  = 10;

  // bit 8 is reserved
  localparam logic [SRC_W_DEF-1:0] SRC_USED_DEF = 10'h2FF;

  localparam logic [ADDR_W_DEF-1:0] OFS_STATUS_DEF  = 8'h10;
  localparam logic [ADDR_W_DEF-1:0] OFS_MASK_DEF    = 8'h20;
  localparam logic [ADDR_W_DEF-1:0] OFS_ENABLE_DEF  = 8'h24;
  localparam logic [ADDR_W_DEF-1:0] OFS_DISABLE_DEF = 8'h28;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   wrStatus;
    logic   wrEnable;
    logic   wrDisable;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irq_regs_ctrl.sv
module irq_regs_ctrl
  import irq_regs_pkg::*;
#(
  parameter int                ADDR_W      = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] OFS_STATUS  = OFS_STATUS_DEF,
  parameter logic [ADDR_W-1:0] OFS_MASK    = OFS_MASK_DEF,
  parameter logic [ADDR_W-1:0] OFS_ENABLE  = OFS_ENABLE_DEF,
  parameter logic [ADDR_W-1:0] OFS_DISABLE = OFS_DISABLE_DEF
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        strb
);

  always_comb begin
    strb.wrStatus  = busWe && (busAddr == OFS_STATUS);
    strb.wrEnable  = busWe && (busAddr == OFS_ENABLE);
    strb.wrDisable = busWe && (busAddr == OFS_DISABLE);
    if (busAddr == OFS_STATUS)    strb.rdSel = RD_STATUS;
    else if (busAddr == OFS_MASK) strb.rdSel = RD_MASK;
    else                          strb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/irq_regs_dp.sv
module irq_regs_dp
  import irq_regs_pkg::*;
#(
  parameter int               SRC_W    = SRC_W_DEF,
  parameter logic [SRC_W-1:0] SRC_USED = SRC_USED_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [SRC_W-1:0] wrBits,
  input  logic [SRC_W-1:0] evtPulse,
  output logic [SRC_W-1:0] rdBits,
  output logic [SRC_W-1:0] statusQ,
  output logic [SRC_W-1:0] maskQ,
  output logic             irqQ
);

  logic [SRC_W-1:0] clrBits;
  logic [SRC_W-1:0] setMask;
  logic [SRC_W-1:0] clrMask;

  assign clrBits = strb.wrStatus  ? wrBits : '0;
  assign setMask = strb.wrEnable  ? wrBits : '0;
  assign clrMask = strb.wrDisable ? wrBits : '0;

  for (genvar i = 0; i < SRC_W; i++) begin : gBit
    if (SRC_USED[i]) begin : gLive
      logic stBit;
      logic mkBit;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stBit <= 1'b0;
          mkBit <= 1'b0;
        end else begin
          // an event in the same cycle wins over the clear
          stBit <= (stBit & ~clrBits[i]) | evtPulse[i];
          mkBit <= (mkBit | setMask[i]) & ~clrMask[i];
        end
      end
      assign statusQ[i] = stBit;
      assign maskQ[i]   = mkBit;
    end else begin : gRsvd
      assign statusQ[i] = 1'b0;
      assign maskQ[i]   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(statusQ & maskQ);
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_STATUS: rdBits = statusQ;
      RD_MASK:   rdBits = maskQ;
      default:   rdBits = '0;
    endcase
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_regs_pkg::*;
#(
  parameter int                ADDR_W      = ADDR_W_DEF,
  parameter int                DATA_W      = DATA_W_DEF,
  parameter int                SRC_W       = SRC_W_DEF,
  parameter logic [SRC_W-1:0]  SRC_USED    = SRC_USED_DEF,
  parameter logic [ADDR_W-1:0] OFS_STATUS  = OFS_STATUS_DEF,
  parameter logic [ADDR_W-1:0] OFS_MASK    = OFS_MASK_DEF,
  parameter logic [ADDR_W-1:0] OFS_ENABLE  = OFS_ENABLE_DEF,
  parameter logic [ADDR_W-1:0] OFS_DISABLE = OFS_DISABLE_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_W-1:0]  evtPulse,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  localparam int PAD_W = DATA_W - SRC_W;

  regStrobe_t       strb;
  logic [SRC_W-1:0] rdBits;
  logic [SRC_W-1:0] statusQ;
  logic [SRC_W-1:0] maskQ;

  irq_regs_ctrl #(
    .ADDR_W(ADDR_W), .OFS_STATUS(OFS_STATUS), .OFS_MASK(OFS_MASK),
    .OFS_ENABLE(OFS_ENABLE), .OFS_DISABLE(OFS_DISABLE)
  ) uCtrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strb   (strb)
  );

  irq_regs_dp #(
    .SRC_W(SRC_W), .SRC_USED(SRC_USED)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrBits  (busWdata[SRC_W-1:0]),
    .evtPulse(evtPulse),
    .rdBits  (rdBits),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .irqQ    (irqOut)
  );

  assign busRdata = {{PAD_W{1'b0}}, rdBits};

endmodule

// File: rtl/irq_regs_chk.sv
module irq_regs_chk #(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 32,
  parameter int                SRC_W       = 10,
  parameter logic [SRC_W-1:0]  SRC_USED    = 10'h2FF,
  parameter logic [ADDR_W-1:0] OFS_STATUS  = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK    = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_ENABLE  = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_DISABLE = 8'h28
) (
  input logic              clk,
  input logic              rstN,
  input logic [SRC_W-1:0]  evtPulse,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic [SRC_W-1:0]  statusView,
  input logic [SRC_W-1:0]  maskView
);

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  logic [SRC_W-1:0] clrReq;
  assign clrReq = (busWe && busAddr == OFS_STATUS) ? busWdata[SRC_W-1:0] : '0;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> ((($past(evtPulse) & SRC_USED) & ~statusView) == '0)); // R2

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> ((($past(statusView) & ~$past(clrReq)) & ~statusView) == '0)); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (($past(clrReq) & ~$past(evtPulse) & statusView) == '0)); // R3

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFS_ENABLE) |=>
      ((~maskView & $past(busWdata[SRC_W-1:0]) & SRC_USED) == '0)); // R5

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFS_DISABLE) |=>
      ((maskView & $past(busWdata[SRC_W-1:0])) == '0)); // R6

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && (busAddr == OFS_ENABLE || busAddr == OFS_DISABLE)) |=>
      $stable(maskView)); // R10

  AST_MASK_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFS_MASK) |-> (busRdata == DATA_W'(maskView))); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (((statusView | maskView) & ~SRC_USED) == '0)); // R8

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (irqOut == $past(|(statusView & maskView)))); // R9

endmodule

bind irq_regs irq_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .SRC_USED(SRC_USED),
  .OFS_STATUS(OFS_STATUS), .OFS_MASK(OFS_MASK),
  .OFS_ENABLE(OFS_ENABLE), .OFS_DISABLE(OFS_DISABLE)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .evtPulse  (evtPulse),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .irqOut    (irqOut),
  .statusView(statusQ),
  .maskView  (maskQ)
);

// File: tb/sim_irq_regs.sv
module sim_irq_regs;

  localparam int CLK_PERIOD = 10;
  localparam int USED = 'h2FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  evtPulse = '0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural reference state
  int mStat = 0;
  int mMask = 0;
  bit mIrq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_regs u0 (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStat = 0; mMask = 0; mIrq = 0;
    end else begin
      int clr;
      int d;
      d = int'(busWdata) & USED;
      mIrq = ((mStat & mMask) != 0);
      clr = (busWe && busAddr == 8'h10) ? d : 0;
      mStat = (mStat & ~clr) | (int'(evtPulse) & USED);
      if (busWe && busAddr == 8'h24) mMask = mMask | d;
      if (busWe && busAddr == 8'h28) mMask = mMask & ~d;
    end
  end

  function automatic int expRead(input logic [7:0] a);
    if (a == 8'h10) return mStat;
    if (a == 8'h20) return mMask;
    return 0;
  endfunction

  task automatic compare();
    int er;
    er = expRead(busAddr);
    total++;
    if (busRdata !== 32'(er)) begin
      bad++;
      $display("FAIL %s read @%02h: actual=%08h expected=%08h", curReq, busAddr, busRdata, er);
    end
    total++;
    if (irqOut !== mIrq) begin
      bad++;
      $display("FAIL %s irqOut: actual=%b expected=%b", curReq, irqOut, mIrq);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input logic we, input logic [31:0] d, input logic [9:0] e);
    @(negedge clk);
    busAddr = a; busWe = we; busWdata = d; evtPulse = e;
    #1;
    compare();
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(a, 1'b0, 32'h0, 10'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state at every offset
    curReq = "R1";
    @(posedge clk);
    rd(8'h10); rd(8'h20); rd(8'h24); rd(8'h28);
    @(negedge clk); rstN = 1'b1;
    rd(8'h10); rd(8'h20);

    // R2: events set sticky bits
    curReq = "R2";
    cyc(8'h10, 0, 0, 10'h001);
    rd(8'h10);
    cyc(8'h10, 0, 0, 10'h200);
    cyc(8'h10, 0, 0, 10'h020);
    rd(8'h10); rd(8'h10);

    // R3: write-one-to-clear, zeros leave bits
    curReq = "R3";
    cyc(8'h10, 1, 32'h001, 10'h0);
    rd(8'h10);
    cyc(8'h10, 1, 32'h000, 10'h0);
    rd(8'h10);

    // R4: event and clear collide on bit 3
    curReq = "R4";
    cyc(8'h10, 0, 0, 10'h008);
    cyc(8'h10, 1, 32'h008, 10'h008);
    rd(8'h10);

    // R5: enable sets mask bits
    curReq = "R5";
    cyc(8'h24, 1, 32'h201, 10'h0);
    rd(8'h20);
    cyc(8'h24, 1, 32'h000, 10'h0);
    rd(8'h20);

    // R9: irq follows status and mask one cycle later
    curReq = "R9";
    cyc(8'h24, 1, 32'h020, 10'h0);
    rd(8'h10); rd(8'h10);
    cyc(8'h10, 1, 32'h228, 10'h0);
    rd(8'h10); rd(8'h10);
    cyc(8'h10, 0, 0, 10'h004);
    rd(8'h10);
    cyc(8'h24, 1, 32'h004, 10'h0);
    rd(8'h10); rd(8'h10);

    // R6: disable clears mask bits
    curReq = "R6";
    cyc(8'h28, 1, 32'h004, 10'h0);
    rd(8'h20); rd(8'h20);
    cyc(8'h28, 1, 32'h000, 10'h0);
    rd(8'h20);

    // R7: write-only offsets read zero, mask readable
    curReq = "R7";
    rd(8'h24); rd(8'h28); rd(8'h20);

    // R8: reserved bit and upper bits
    curReq = "R8";
    cyc(8'h24, 1, 32'hFFFF_FFFF, 10'h0);
    rd(8'h20);
    cyc(8'h10, 0, 0, 10'h100);
    rd(8'h10);
    cyc(8'h10, 1, 32'hFFFF_FFFF, 10'h0);
    rd(8'h10);

    // R10: other offsets change nothing
    curReq = "R10";
    cyc(8'h10, 0, 0, 10'h011);
    cyc(8'h14, 1, 32'hFFFF_FFFF, 10'h0);
    cyc(8'h00, 1, 32'hFFFF_FFFF, 10'h0);
    cyc(8'h1C, 1, 32'hFFFF_FFFF, 10'h0);
    rd(8'h10); rd(8'h20); rd(8'h14);

    // mixed random traffic against the reference model
    curReq = "R2/R3/R5/R6/R9";
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: a = 8'h10;
        1: a = 8'h20;
        2: a = 8'h24;
        3: a = 8'h28;
        4: a = 8'h10;
        default: a = 8'h30;
      endcase
      cyc(a, $urandom_range(0, 2) == 0, $urandom, 10'($urandom) & 10'($urandom));
    end

    // R1: reset asserted mid-run returns everything to zero
    curReq = "R1";
    @(negedge clk); rstN = 1'b0;
    rd(8'h10); rd(8'h20);
    @(negedge clk); rstN = 1'b1;
    rd(8'h10);

    finish_run();
  end

endmodule